// File: doc/BRIEF.md
# MSI Doorbell Interrupt Collector

This block gathers message-signalled interrupts into one level-sensitive interrupt line. Software programs a 64-bit doorbell address, a per-vector enable word and a per-vector mask word through a 32-bit register port. Endpoints raise interrupts by writing a data word to that doorbell address on a separate inbound write port. The data value names a vector from 0 to 31. If that vector is enabled, its bit in a 32-bit pending word is set.

The interrupt line rises as soon as any pending bit is unmasked. It stays high until software has cleared the whole pending word. Software clears pending bits by writing ones to the pending register, and each one toggles the matching bit. The doorbell window is only live while at least one vector is enabled.

Reset is asynchronous and active low. It is released into the block's clock domain through a two-stage synchroniser, so the block leaves reset two clock edges after the reset input goes high.

Top module: `msi_doorbell_collector`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Register offsets (byte addresses on `reg_addr`) are:
  - 0x820: doorbell base, low word.
  - 0x824: doorbell base, high word.
  - 0x828: vector enable.
  - 0x82C: vector mask.
  - 0x830: pending.

  `reg_rdata` shows the stored value of the register addressed by `reg_addr` in the same cycle. Any other offset reads 0, and a write to it changes nothing.
- R3: A write to the low or the high base word replaces only that 32-bit half of the 64-bit doorbell base.
- R4: A doorbell write counts as a hit when all of the following hold:
  - `db_valid` is high.
  - `db_addr` equals the 64-bit base exactly.
  - `db_be` is 4'hF.
  - The enable register is nonzero.

  A hit with data value N, where enable bit N is set, sets pending bit N at the next clock edge.
- R5: A hit whose data value N has enable bit N clear leaves the pending word unchanged. While the enable register is 0, no doorbell write has any effect.
- R6: Each of the following leaves the pending word unchanged:
  - A doorbell write whose address differs from the base, including base+4.
  - A doorbell write with any byte enable low.
  - A data value of 32 or more.
- R7: `irq` is high at the clock edge after which any pending bit has its mask bit clear. This includes the case where the mask is cleared while bits are pending.
- R8: A register write to the pending offset toggles every pending bit where the written word has a 1.
- R9: Once high, `irq` goes low only at the edge after which the whole pending word is 0. Masking pending bits, or clearing only some of them, leaves `irq` high.
- R10: A write to the mask register does not change the pending word.
- R11: When a doorbell hit and a pending-register write fall in the same cycle, the vector bit is set first and the toggle is applied to that result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| db_valid | input | 1 | Inbound doorbell write strobe |
| db_addr | input | 64 | Inbound write address |
| db_be | input | 4 | Inbound byte enables |
| db_data | input | 32 | Inbound write data (vector number) |
| irq | output | 1 | Level interrupt output |

## Verification
The state that is hardest to reach from the ports is an `irq` line that is high while every pending bit is masked. In that state, only a full clear of the pending word may drop the line. The stimulus gets there in three steps:
1. It rings a masked vector and checks that `irq` stays low.
2. It unmasks that vector, which raises the line.
3. It masks the vector again and clears a second pending vector.

Then it checks that the line holds until the last bit is toggled away. A separate scenario drives a doorbell hit and a pending write in the same cycle. It covers both a toggle of the bit being set and a toggle of a different bit.

// File: rtl/msi_dbl_pkg.sv
package msi_dbl_pkg;
  localparam int REG_W   = 32;
  localparam int REG_AW  = 12;
  localparam int NUM_VEC = REG_W;
  localparam int BASE_W  = 2 * REG_W;
  localparam int BE_W    = REG_W / 8;

  localparam logic [REG_AW-1:0] OFS_BASE_LO = 12'h820;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 12'h824;
  localparam logic [REG_AW-1:0] OFS_ENABLE  = 12'h828;
  localparam logic [REG_AW-1:0] OFS_MASK    = 12'h82C;
  localparam logic [REG_AW-1:0] OFS_PEND    = 12'h830;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BASE_LO,
    SEL_BASE_HI,
    SEL_ENABLE,
    SEL_MASK,
    SEL_PEND
  } reg_sel_e;
endpackage

// File: rtl/msi_dbl_regfile.sv
module msi_dbl_regfile
  import msi_dbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic [NUM_VEC-1:0] pend_q,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [BASE_W-1:0]  base_q,
  output logic [NUM_VEC-1:0] enable_q,
  output logic [NUM_VEC-1:0] mask_q,
  output logic [NUM_VEC-1:0] mask_nxt,
  output logic               pend_wr
);
  reg_sel_e            sel;
  logic [BASE_W-1:0]   base_d;
  logic [NUM_VEC-1:0]  enable_d;
  logic                base_en, enable_en, mask_en;

  always_comb begin
    unique case (reg_addr)
      OFS_BASE_LO: sel = SEL_BASE_LO;
      OFS_BASE_HI: sel = SEL_BASE_HI;
      OFS_ENABLE:  sel = SEL_ENABLE;
      OFS_MASK:    sel = SEL_MASK;
      OFS_PEND:    sel = SEL_PEND;
      default:     sel = SEL_NONE;
    endcase
  end

  always_comb begin
    base_en   = reg_wr && (sel == SEL_BASE_LO || sel == SEL_BASE_HI);
    enable_en = reg_wr && (sel == SEL_ENABLE);
    mask_en   = reg_wr && (sel == SEL_MASK);
    pend_wr   = reg_wr && (sel == SEL_PEND);
    base_d    = base_q;
    if (sel == SEL_BASE_LO) base_d[REG_W-1:0]      = reg_wdata;
    if (sel == SEL_BASE_HI) base_d[BASE_W-1:REG_W] = reg_wdata;
    enable_d  = reg_wdata;
    mask_nxt  = mask_en ? reg_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      enable_q <= '0;
      mask_q   <= '0;
    end else begin
      if (base_en)   base_q   <= base_d;
      if (enable_en) enable_q <= enable_d;
      if (mask_en)   mask_q   <= mask_nxt;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_BASE_LO: reg_rdata = base_q[REG_W-1:0];
      SEL_BASE_HI: reg_rdata = base_q[BASE_W-1:REG_W];
      SEL_ENABLE:  reg_rdata = enable_q;
      SEL_MASK:    reg_rdata = mask_q;
      SEL_PEND:    reg_rdata = pend_q;
      default:     reg_rdata = '0;
    endcase
  end

  AST_HALF_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_BASE_LO) |=> $stable(base_q[BASE_W-1:REG_W])); // R3
  AST_HALF_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_BASE_HI) |=> $stable(base_q[REG_W-1:0])); // R3
endmodule

// File: rtl/msi_dbl_decoder.sv
module msi_dbl_decoder
  import msi_dbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               db_valid,
  input  logic [BASE_W-1:0]  db_addr,
  input  logic [BE_W-1:0]    db_be,
  input  logic [REG_W-1:0]   db_data,
  input  logic [BASE_W-1:0]  base_q,
  input  logic [NUM_VEC-1:0] enable_q,
  output logic [NUM_VEC-1:0] set_vec
);
  logic window_live;
  logic hit;

  always_comb begin
    window_live = |enable_q;
    hit = db_valid && window_live && (db_addr == base_q) && (&db_be);
  end

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    assign set_vec[v] = hit && enable_q[v] && (db_data == REG_W'(v));
  end

  AST_ONE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec)); // R4
  AST_WINDOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> (set_vec == '0)); // R5
  AST_FULL_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |-> (db_be == '1)); // R6
endmodule

// File: rtl/msi_dbl_pending.sv
module msi_dbl_pending
  import msi_dbl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] set_vec,
  input  logic               pend_wr,
  input  logic [REG_W-1:0]   pend_wdata,
  input  logic [NUM_VEC-1:0] mask_nxt,
  output logic [NUM_VEC-1:0] pend_q,
  output logic               irq_q
);
  logic [NUM_VEC-1:0] after_set;
  logic [NUM_VEC-1:0] pend_d;
  logic               pend_en;
  logic               irq_d;

  always_comb begin
    after_set = pend_q | set_vec;
    pend_d    = pend_wr ? (after_set ^ pend_wdata) : after_set;
    pend_en   = pend_wr || (set_vec != '0);
    if ((pend_d & ~mask_nxt) != '0) irq_d = 1'b1;
    else if (pend_d == '0)          irq_d = 1'b0;
    else                            irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      irq_q <= irq_d;
    end
  end

  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (pend_q != '0)); // R9
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && set_vec == '0) |=> $stable(pend_q)); // R5
  AST_DROP_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> (pend_q == '0)); // R9
endmodule

// File: rtl/msi_doorbell_collector.sv
module msi_doorbell_collector
  import msi_dbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              db_valid,
  input  logic [BASE_W-1:0] db_addr,
  input  logic [BE_W-1:0]   db_be,
  input  logic [REG_W-1:0]  db_data,
  output logic              irq
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [BASE_W-1:0]      base_q;
  logic [NUM_VEC-1:0]     enable_q, mask_q, mask_nxt, pend_q, set_vec;
  logic                   pend_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  msi_dbl_regfile u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .pend_q(pend_q), .reg_rdata(reg_rdata),
    .base_q(base_q), .enable_q(enable_q), .mask_q(mask_q),
    .mask_nxt(mask_nxt), .pend_wr(pend_wr)
  );

  msi_dbl_decoder u_dec (
    .clk(clk), .rst_n(rst_sync_n), .db_valid(db_valid), .db_addr(db_addr),
    .db_be(db_be), .db_data(db_data), .base_q(base_q),
    .enable_q(enable_q), .set_vec(set_vec)
  );

  msi_dbl_pending u_pend (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_vec), .pend_wr(pend_wr),
    .pend_wdata(reg_wdata), .mask_nxt(mask_nxt), .pend_q(pend_q),
    .irq_q(irq)
  );

  AST_UNMASKED_RAISES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((pend_q & ~mask_q) != '0) |-> irq); // R7
  AST_MASK_WRITE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == OFS_MASK && set_vec == '0) |=> $stable(pend_q)); // R10
endmodule

// File: tb/msi_doorbell_collector_tb.sv
module msi_doorbell_collector_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        db_valid = 1'b0;
  logic [63:0] db_addr = '0;
  logic [3:0]  db_be = '0;
  logic [31:0] db_data = '0;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                          A_MASK = 12'h82C, A_PEND = 12'h830;
  localparam logic [63:0] BASE = 64'h0000_00AB_DEAD_0040;

  always #4 clk = ~clk;

  msi_doorbell_collector u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
    .db_addr(db_addr), .db_be(db_be), .db_data(db_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ring(input logic [63:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    db_valid = 1'b1; db_addr = a; db_be = be; db_data = d;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic ring_and_clear(input logic [31:0] vec, input logic [31:0] tog);
    @(negedge clk);
    db_valid = 1'b1; db_addr = BASE; db_be = 4'hF; db_data = vec;
    reg_wr = 1'b1; reg_addr = A_PEND; reg_wdata = tog;
    @(negedge clk);
    db_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_LO, v);   check("R1 base lo", v, 0);
    rd(A_HI, v);   check("R1 base hi", v, 0);
    rd(A_EN, v);   check("R1 enable", v, 0);
    rd(A_MASK, v); check("R1 mask", v, 0);
    rd(A_PEND, v); check("R1 pending", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(A_LO, 32'h1111_2222);
    wr(A_HI, 32'h0000_00AB);
    rd(A_HI, v); check("R3 hi written", v, 32'h0000_00AB);
    wr(A_LO, BASE[31:0]);
    rd(A_HI, v); check("R3 hi kept after low write", v, 32'h0000_00AB);
    rd(A_LO, v); check("R3 lo replaced", v, BASE[31:0]);
    wr(12'h834, 32'hFFFF_FFFF);
    rd(12'h834, v); check("R2 unknown offset reads 0", v, 0);
    rd(A_MASK, v);  check("R2 unknown write ignored", v, 0);
    wr(A_EN, 32'h8000_0011);
    rd(A_EN, v); check("R2 enable readback", v, 32'h8000_0011);
  endtask

  task automatic t_doorbell();
    logic [31:0] v;
    ring(BASE, 4'hF, 32'd4);
    rd(A_PEND, v); check("R4 vector 4 pending", v, 32'h0000_0010);
    check("R7 irq on unmasked", {31'd0, irq}, 1);
    ring(BASE, 4'hF, 32'd31);
    rd(A_PEND, v); check("R4 vector 31 pending", v, 32'h8000_0010);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    ring(BASE, 4'hF, 32'd1);
    rd(A_PEND, v); check("R5 disabled vector ignored", v, 32'h8000_0010);
    ring(BASE + 64'd4, 4'hF, 32'd0);
    rd(A_PEND, v); check("R6 base+4 ignored", v, 32'h8000_0010);
    ring(BASE, 4'h3, 32'd0);
    rd(A_PEND, v); check("R6 partial bytes ignored", v, 32'h8000_0010);
    ring(BASE, 4'hF, 32'd36);
    rd(A_PEND, v); check("R6 data >= 32 ignored", v, 32'h8000_0010);
    wr(A_PEND, 32'h8000_0000);
    rd(A_PEND, v); check("R8 toggle clears bit 31", v, 32'h0000_0010);
    check("R9 irq held while nonzero", {31'd0, irq}, 1);
    wr(A_PEND, 32'h0000_0010);
    rd(A_PEND, v); check("R8 toggle clears bit 4", v, 0);
    check("R9 irq drops at zero", {31'd0, irq}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(A_MASK, 32'h0000_0001);
    ring(BASE, 4'hF, 32'd0);
    rd(A_PEND, v); check("R4 masked vector pending", v, 32'h1);
    check("R7 masked gives no irq", {31'd0, irq}, 0);
    wr(A_MASK, 32'h0);
    rd(A_PEND, v); check("R10 mask write keeps pending", v, 32'h1);
    check("R7 unmask raises irq", {31'd0, irq}, 1);
    wr(A_MASK, 32'h0000_0001);
    check("R9 remask keeps irq", {31'd0, irq}, 1);
    ring(BASE, 4'hF, 32'd4);
    wr(A_PEND, 32'h0000_0010);
    rd(A_PEND, v); check("R8 partial clear", v, 32'h1);
    check("R9 irq held with masked leftover", {31'd0, irq}, 1);
    wr(A_PEND, 32'h1);
    check("R9 irq low after full clear", {31'd0, irq}, 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    ring_and_clear(32'd4, 32'h0000_0010);
    rd(A_PEND, v); check("R11 set then toggle same bit", v, 0);
    check("R11 irq stays low", {31'd0, irq}, 0);
    ring_and_clear(32'd0, 32'h0000_0010);
    rd(A_PEND, v); check("R11 set and toggle other bit", v, 32'h11);
    check("R11 irq from unmasked bit 4", {31'd0, irq}, 1);
    wr(A_PEND, 32'h11);
    check("R9 cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_window_off();
    logic [31:0] v;
    wr(A_EN, 32'h0);
    ring(BASE, 4'hF, 32'd4);
    rd(A_PEND, v); check("R5 window closed at enable 0", v, 0);
    check("R5 irq low", {31'd0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_doorbell();
    t_ignored();
    t_mask();
    t_same_cycle();
    t_window_off();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule